// File: doc/BRIEF.md
# Protected Page Debug Write Gate

This block sits between a debugger access path and protected memory. It decides whether one debugger store into a protected page is allowed. A request carries the following inputs:

- the target address and the write data;
- the width mode and the current privilege level;
- a hit signal for the protected region;
- the page's metadata from a lookup port;
- the owner's debug attribute, returned for the owner the block names on `owner_sel`;
- a conflict signal from operations running at the same time.

The block evaluates its rules in a fixed priority order. It then produces exactly one of three results: a general protection fault, a page fault, or a completion.

A completion is either a soft error or a successful write. A soft error occurs when the page is busy, meaning pending or modified. In that case the block returns an error code and sets the zero flag, and it writes nothing. A successful write returns a zero code and drives a byte-masked write toward memory. Wide mode stores the whole data word. Narrow mode stores half of it, in the lane that the address selects. On a control page, only the single word that holds the flags field can be written.

Top module: `dbgwr_gate`

## Requirements
- R1: `req_ready` is high whenever no result is being presented. An accepted request (`req_valid && req_ready` at a clock edge) raises `done` for exactly one cycle, starting at the next edge. `req_ready` is low during that cycle.
- R2: A privilege level other than 0 gives fault code 2'b01 (general protection). This check comes before every other check.
- R3: A misaligned address gives 2'b01. In wide mode an address is misaligned when `req_addr[2:0]` is not 0. In narrow mode it is misaligned when `req_addr[1:0]` is not 0. This check is second in priority.
- R4: If the first two checks pass, a region miss gives 2'b10 (page fault). This check comes before the conflict check. A metadata entry with its valid bit clear also gives 2'b10; this check comes after the conflict check.
- R5: If the privilege, alignment and region checks pass, an asserted `conflict` gives 2'b01.
- R6: The page type encodings are 0 regular, 1 control, 2 shadow-stack first and 3 shadow-stack rest. Any type from 4 to 7 gives 2'b10 once the valid check has passed.
- R7: A pending or modified page is handled as follows, once the earlier checks pass:
  - fault code 2'b00;
  - `ret_code` set to ERR_CODE (default 1);
  - the zero flag set;
  - no write.
- R8: On a control page (type 1), `req_addr[11:3]` must equal bits [11:3] of FLAGS_OFF (default 12'h008). A mismatch gives 2'b01. This check comes after the busy check.
- R9: An owner debug attribute of 0 gives 2'b01. This is the last check.
- R10: A request that passes every check is reported and written as follows:
  - `ret_code` is 0 and `wr_en` is high;
  - `wr_addr` equals the request address;
  - in wide mode, `wr_strb` is 8'hFF and `wr_data` equals the request data;
  - in narrow mode, `wr_strb` is 8'h0F when `req_addr[2]` is 0 and 8'hF0 when it is 1, and `wr_data` holds the low 32 data bits in both halves.

  `wr_en` is never high with a fault or outside a `done` cycle.
- R11: `flags` bit 0 is carry, bit 1 parity, bit 2 auxiliary, bit 3 zero, bit 4 sign and bit 5 overflow. In every result, every bit except the zero bit is 0. The zero bit is 1 only for a busy page. On a fault `ret_code` and `flags` are 0.
- R12: `owner_sel` follows `pg_owner` combinationally, so that the owner's debug attribute can be looked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | AW | Target address |
| req_data | input | DW | Store data |
| req_mode64 | input | 1 | 1 = wide (8-byte) store, 0 = narrow (4-byte) |
| req_cpl | input | 2 | Current privilege level |
| region_hit | input | 1 | Address lies inside the protected region |
| pg_valid | input | 1 | Metadata entry valid |
| pg_type | input | 3 | Page type |
| pg_pending | input | 1 | Page pending |
| pg_modified | input | 1 | Page modified |
| pg_owner | input | OWN_W | Owner identifier of the page |
| owner_sel | output | OWN_W | Owner selected for the debug attribute lookup |
| owner_debug | input | 1 | Debug attribute of the selected owner |
| conflict | input | 1 | Another operation is changing the same entry |
| done | output | 1 | One-cycle result strobe |
| fault | output | 2 | 00 none, 01 general protection, 10 page fault |
| ret_code | output | RET_W | Return code |
| flags | output | 6 | Status flags |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | AW | Memory write address |
| wr_data | output | DW | Memory write data |
| wr_strb | output | DW/8 | Byte strobe |

## Verification
The hardest situations to reach are the ones deep in the priority chain, where a lower rule is masked by a higher one. Examples are a control-page offset mismatch on a busy page, and a missing debug attribute on a page that would otherwise fail the type check. The bench reaches these by sweeping every combination of the following:

- privilege;
- width mode;
- six address offsets, which cover the aligned, misaligned, flags-word and non-flags-word cases;
- the region, conflict, valid, pending, modified and debug inputs;
- all eight page types.

For each request a priority model in the bench predicts which rule must win.

// File: rtl/dbgwr_pkg.sv
package dbgwr_pkg;

    typedef enum logic [1:0] {
        OUT_NONE = 2'b00,
        OUT_GP   = 2'b01,
        OUT_PF   = 2'b10
    } outcome_e;

    typedef enum logic [2:0] {
        PG_REG      = 3'd0,
        PG_CTRL     = 3'd1,
        PG_SS_FIRST = 3'd2,
        PG_SS_REST  = 3'd3
    } pgtype_e;

    localparam int FLAG_W    = 6;
    localparam int FL_CARRY  = 0;
    localparam int FL_PARITY = 1;
    localparam int FL_AUX    = 2;
    localparam int FL_ZERO   = 3;
    localparam int FL_SIGN   = 4;
    localparam int FL_OVF    = 5;

endpackage

// File: rtl/dbgwr_rules.sv
module dbgwr_rules
    import dbgwr_pkg::*;
#(
    parameter logic [11:0] FLAGS_OFF = 12'h008
) (
    input  logic       mode64,
    input  logic [1:0] cpl,
    input  logic [11:0] addr_lo,
    input  logic       region_hit,
    input  logic       conflict,
    input  logic       pg_valid,
    input  logic [2:0] pg_type,
    input  logic       pg_pending,
    input  logic       pg_modified,
    input  logic       owner_debug,
    output outcome_e   outcome,
    output logic       soft_err
);

    localparam logic [8:0] FLAG_QW = FLAGS_OFF[11:3];

    logic misalign;
    logic type_ok;
    logic is_ctrl;

    always_comb begin
        misalign = mode64 ? (addr_lo[2:0] != 3'b000) : (addr_lo[1:0] != 2'b00);
        case (pg_type)
            PG_REG, PG_CTRL, PG_SS_FIRST, PG_SS_REST: type_ok = 1'b1;
            default:                                  type_ok = 1'b0;
        endcase
        is_ctrl = (pg_type == PG_CTRL);

        outcome  = OUT_NONE;
        soft_err = 1'b0;
        // priority chain: first failing rule decides
        if (cpl != 2'd0)                               outcome = OUT_GP;
        else if (misalign)                             outcome = OUT_GP;
        else if (!region_hit)                          outcome = OUT_PF;
        else if (conflict)                             outcome = OUT_GP;
        else if (!pg_valid)                            outcome = OUT_PF;
        else if (!type_ok)                             outcome = OUT_PF;
        else if (pg_pending || pg_modified)            soft_err = 1'b1;
        else if (is_ctrl && (addr_lo[11:3] != FLAG_QW)) outcome = OUT_GP;
        else if (!owner_debug)                         outcome = OUT_GP;
    end

endmodule

// File: rtl/dbgwr_lanes.sv
module dbgwr_lanes #(
    parameter int DW = 64
) (
    input  logic            mode64,
    input  logic            upper,
    input  logic [DW-1:0]   data,
    output logic [DW/8-1:0] strb,
    output logic [DW-1:0]   wdata
);

    localparam int NB = DW / 8;
    localparam int HB = NB / 2;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        localparam bit HI = (b >= HB);
        assign strb[b]          = mode64 || (upper == HI);
        assign wdata[b*8 +: 8]  = mode64 ? data[b*8 +: 8] : data[(b % HB)*8 +: 8];
    end

endmodule

// File: rtl/dbgwr_gate.sv
module dbgwr_gate
    import dbgwr_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 64,
    parameter int          OWN_W     = 8,
    parameter int          RET_W     = 8,
    parameter logic [11:0] FLAGS_OFF = 12'h008,
    parameter int          ERR_CODE  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_data,
    input  logic              req_mode64,
    input  logic [1:0]        req_cpl,
    input  logic              region_hit,
    input  logic              pg_valid,
    input  logic [2:0]        pg_type,
    input  logic              pg_pending,
    input  logic              pg_modified,
    input  logic [OWN_W-1:0]  pg_owner,
    output logic [OWN_W-1:0]  owner_sel,
    input  logic              owner_debug,
    input  logic              conflict,
    output logic              done,
    output logic [1:0]        fault,
    output logic [RET_W-1:0]  ret_code,
    output logic [FLAG_W-1:0] flags,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [DW/8-1:0]   wr_strb
);

    localparam int             NB      = DW / 8;
    localparam logic [RET_W-1:0] ERR_RET = RET_W'(ERR_CODE);

    typedef struct packed {
        logic              done;
        logic [1:0]        fault;
        logic [RET_W-1:0]  ret;
        logic [FLAG_W-1:0] flags;
        logic              wr_en;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     data;
        logic [NB-1:0]     strb;
    } res_t;

    res_t     res_d, res_q;
    outcome_e chk_out;
    logic     chk_soft;
    logic [NB-1:0] lane_strb;
    logic [DW-1:0] lane_data;
    logic     take;

    dbgwr_rules #(.FLAGS_OFF(FLAGS_OFF)) u_rules (
        .mode64      (req_mode64),
        .cpl         (req_cpl),
        .addr_lo     (req_addr[11:0]),
        .region_hit  (region_hit),
        .conflict    (conflict),
        .pg_valid    (pg_valid),
        .pg_type     (pg_type),
        .pg_pending  (pg_pending),
        .pg_modified (pg_modified),
        .owner_debug (owner_debug),
        .outcome     (chk_out),
        .soft_err    (chk_soft)
    );

    dbgwr_lanes #(.DW(DW)) u_lanes (
        .mode64 (req_mode64),
        .upper  (req_addr[2]),
        .data   (req_data),
        .strb   (lane_strb),
        .wdata  (lane_data)
    );

    assign req_ready = !res_q.done;
    assign take      = req_valid && req_ready;
    assign owner_sel = pg_owner;

    always_comb begin
        res_d       = res_q;
        res_d.done  = 1'b0;
        res_d.wr_en = 1'b0;
        if (take) begin
            res_d.done  = 1'b1;
            res_d.fault = chk_out;
            res_d.ret   = '0;
            res_d.flags = '0;
            res_d.addr  = req_addr;
            res_d.data  = lane_data;
            res_d.strb  = lane_strb;
            if (chk_out == OUT_NONE) begin
                if (chk_soft) begin
                    res_d.ret             = ERR_RET;
                    res_d.flags[FL_ZERO]  = 1'b1;
                end else begin
                    res_d.wr_en = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign done     = res_q.done;
    assign fault    = res_q.fault;
    assign ret_code = res_q.ret;
    assign flags    = res_q.flags;
    assign wr_en    = res_q.wr_en;
    assign wr_addr  = res_q.addr;
    assign wr_data  = res_q.data;
    assign wr_strb  = res_q.strb;

endmodule

// File: rtl/dbgwr_gate_chk.sv
module dbgwr_gate_chk #(
    parameter int RET_W = 8,
    parameter int NB    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_cpl,
    input logic             done,
    input logic [1:0]       fault,
    input logic [RET_W-1:0] ret_code,
    input logic [5:0]       flags,
    input logic             wr_en,
    input logic [NB-1:0]    wr_strb
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                     // R1
    AST_ACCEPT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> done);                                  // R1
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);                                                // R1
    AST_CPL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cpl != 2'd0) |=> (done && fault == 2'b01)); // R2
    AST_SOFT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ret_code != '0) |-> (!wr_en && flags[3] && fault == 2'b00)); // R7
    AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'b00) |-> (!wr_en && ret_code == '0));            // R10
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !wr_en);                                                   // R10
    AST_STRB_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(wr_strb) == NB || $countones(wr_strb) == NB/2)); // R10
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((flags & 6'b110111) == 6'b000000));                        // R11

endmodule

bind dbgwr_gate dbgwr_gate_chk #(.RET_W(RET_W), .NB(DW/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cpl   (req_cpl),
    .done      (done),
    .fault     (fault),
    .ret_code  (ret_code),
    .flags     (flags),
    .wr_en     (wr_en),
    .wr_strb   (wr_strb)
);

// File: tb/tb_dbgwr_gate.sv
`timescale 1ns/1ps
module tb_dbgwr_gate;

    localparam int AW = 32, DW = 64, OWN_W = 8, RET_W = 8;
    localparam logic [11:0] FOFF = 12'h008;
    localparam int ERRC = 1;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic req_mode64;
    logic [1:0] req_cpl;
    logic region_hit, pg_valid, pg_pending, pg_modified, owner_debug, conflict;
    logic [2:0] pg_type;
    logic [OWN_W-1:0] pg_owner, owner_sel;
    logic done, wr_en;
    logic [1:0] fault;
    logic [RET_W-1:0] ret_code;
    logic [5:0] flags;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [7:0] wr_strb;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dbgwr_gate #(.AW(AW), .DW(DW), .OWN_W(OWN_W), .RET_W(RET_W),
                 .FLAGS_OFF(FOFF), .ERR_CODE(ERRC)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_mode64(req_mode64),
        .req_cpl(req_cpl), .region_hit(region_hit), .pg_valid(pg_valid),
        .pg_type(pg_type), .pg_pending(pg_pending), .pg_modified(pg_modified),
        .pg_owner(pg_owner), .owner_sel(owner_sel), .owner_debug(owner_debug),
        .conflict(conflict), .done(done), .fault(fault), .ret_code(ret_code),
        .flags(flags), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // result kinds: 0 write, 1 gp, 2 pf, 3 busy
    function automatic int model(input bit m64, input int cpl, input logic [11:0] a,
                                 input bit hit, input bit cf, input bit vld,
                                 input int ty, input bit pend, input bit modi,
                                 input bit dbg, output string tag);
        tag = "R10";
        if (cpl != 0)                            begin tag = "R2"; return 1; end
        if (m64 ? (a % 8 != 0) : (a % 4 != 0))  begin tag = "R3"; return 1; end
        if (!hit)                                begin tag = "R4"; return 2; end
        if (cf)                                  begin tag = "R5"; return 1; end
        if (!vld)                                begin tag = "R4"; return 2; end
        if (ty > 3)                              begin tag = "R6"; return 2; end
        if (pend || modi)                        begin tag = "R7"; return 3; end
        if (ty == 1 && (a / 8) != (FOFF / 8))   begin tag = "R8"; return 1; end
        if (!dbg)                                begin tag = "R9"; return 1; end
        return 0;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL R1 watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] offs [6];
        int idx;
        offs[0] = 12'h008; offs[1] = 12'h00C; offs[2] = 12'h010;
        offs[3] = 12'h004; offs[4] = 12'h00A; offs[5] = 12'h009;
        idx = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0;
        req_mode64 = 1'b0; req_cpl = 2'd0; region_hit = 1'b0; pg_valid = 1'b0;
        pg_type = 3'd0; pg_pending = 1'b0; pg_modified = 1'b0; pg_owner = '0;
        owner_debug = 1'b0; conflict = 1'b0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && wr_en == 1'b0, "R1 reset done/wr", {62'd0, done, wr_en}, 64'd0);
        chk(fault == 2'b00 && ret_code == '0 && flags == '0, "R11 reset status",
            {48'd0, fault, ret_code, flags}, 64'd0);
        chk(req_ready == 1'b1, "R1 reset ready", {63'd0, req_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);

        pg_owner = 8'h5A; #1;
        chk(owner_sel == 8'h5A, "R12 owner select", {56'd0, owner_sel}, 64'h5A);
        pg_owner = 8'hC3; #1;
        chk(owner_sel == 8'hC3, "R12 owner select", {56'd0, owner_sel}, 64'hC3);

        for (int ci = 0; ci < 2; ci++)
        for (int m = 0; m < 2; m++)
        for (int o = 0; o < 6; o++)
        for (int h = 0; h < 2; h++)
        for (int c = 0; c < 2; c++)
        for (int v = 0; v < 2; v++)
        for (int t = 0; t < 8; t++)
        for (int p = 0; p < 2; p++)
        for (int md = 0; md < 2; md++)
        for (int d = 0; d < 2; d++) begin
            string tag;
            int kind;
            logic [AW-1:0] a;
            logic [DW-1:0] dat;
            logic [DW-1:0] exp_data;
            logic [7:0] exp_strb;
            logic [1:0] exp_fault;
            logic [RET_W-1:0] exp_ret;
            logic [5:0] exp_flags;
            a   = 32'h0004_5000 | {20'd0, offs[o]};
            dat = {32'hDEAD_BEEF ^ 32'(idx), 32'h1234_0000 + 32'(idx)};
            idx++;
            kind = model(m[0], ci * 2, offs[o], h[0], c[0], v[0], t, p[0], md[0], d[0], tag);
            exp_fault = (kind == 1) ? 2'b01 : (kind == 2) ? 2'b10 : 2'b00;
            exp_ret   = (kind == 3) ? RET_W'(ERRC) : '0;
            exp_flags = (kind == 3) ? 6'b001000 : 6'b000000;
            exp_strb  = m[0] ? 8'hFF : (a[2] ? 8'hF0 : 8'h0F);
            exp_data  = m[0] ? dat : {2{dat[31:0]}};

            req_addr = a; req_data = dat; req_mode64 = m[0]; req_cpl = 2'(ci * 2);
            region_hit = h[0]; conflict = c[0]; pg_valid = v[0]; pg_type = 3'(t);
            pg_pending = p[0]; pg_modified = md[0]; owner_debug = d[0];
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk(done == 1'b1 && req_ready == 1'b0, "R1 done after accept",
                {62'd0, done, req_ready}, 64'd2);
            chk(fault == exp_fault, tag, {62'd0, fault}, {62'd0, exp_fault});
            chk(ret_code == exp_ret, tag, {56'd0, ret_code}, {56'd0, exp_ret});
            chk(flags == exp_flags, "R11 flags", {58'd0, flags}, {58'd0, exp_flags});
            chk(wr_en == (kind == 0), tag, {63'd0, wr_en}, {63'd0, kind == 0});
            if (kind == 0) begin
                chk(wr_strb == exp_strb, "R10 strobe", {56'd0, wr_strb}, {56'd0, exp_strb});
                chk(wr_data == exp_data, "R10 data", wr_data, exp_data);
                chk(wr_addr == a, "R10 address", {32'd0, wr_addr}, {32'd0, a});
            end
            @(negedge clk);
            chk(done == 1'b0 && wr_en == 1'b0 && req_ready == 1'b1, "R1 pulse end",
                {61'd0, done, wr_en, req_ready}, 64'd1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule